// File: doc/BRIEF.md
# Wake Event Status Register

This block gathers the wake sources of a power-management domain into a set of sticky status flags. Each flag is raised by hardware when its source fires and stays raised until software writes a one to that flag's position. Flags never clear on a write of zero. The sources are a ring-detect pin, an SMBus wake request tagged with its cause, an SCI pulse from the TCO logic, an AC-link wake request and wake requests from two USB controllers.

A combined wake request output is the OR of every flag gated by its enable. The SMBus flag counts as always enabled. A plain write strobe with a data word stands in for the register bus. The status word is always visible on the read port.

Three paths clear flags apart from software. A thermal trip and a power-button override both clear the SMBus flag, but only when a received slave message raised it. A reset requested through a register write clears every flag except the AC-link flag.

Top module: `wake_status_reg`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `rd_data` is 0 and `wake_req` is 0.
- R2: A write with `wr_en` high clears each flag whose bit in `wr_data` is 1 and leaves each flag whose bit is 0 unchanged; the result shows on `rd_data` one cycle after the write.
- R3: The ring flag (bit 8) is set one cycle after `ring_n` goes from 1 to 0. Holding `ring_n` low does not set the flag again after software has cleared it.
- R4: `smb_msg` or `smb_alert` high for one cycle sets the SMBus flag (bit 7) one cycle later, whatever its previous state.
- R5: If the most recent SMBus set came from `smb_msg`, a `therm_trip` or `pb_override` pulse clears bit 7. If the most recent SMBus set came from `smb_alert`, bit 7 is unchanged by these pulses. When both set sources fire in the same cycle, the set counts as an alert set.
- R6: A one-cycle pulse on a source sets its flag one cycle later: `usb1_wake` sets bit 3, `usb2_wake` sets bit 4, `ac_wake` sets bit 5 and `tco_sci` sets bit 6.
- R7: If a source sets a flag in the same cycle that a write clears it, the flag ends up set.
- R8: A `cfg_rst` pulse clears every flag except bit 5 and clears the stored SMBus cause. Bit 5 follows its normal set and clear rules in that cycle. `cfg_rst` takes priority over set events on the other flags.
- R9: `wake_req` is 1 exactly when some flag in bits 3 to 8 is set and its bit in `wake_en` is 1. Bit 7 counts as enabled whatever `wake_en[7]` holds.
- R10: Bits 0 to 2 and 9 to 15 of `rd_data` always read 0, including after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rst | input | 1 | Reset requested by a register write; spares the AC-link flag |
| ring_n | input | 1 | Active-low ring-detect pin |
| smb_msg | input | 1 | SMBus wake set by a received slave message |
| smb_alert | input | 1 | SMBus wake set by the alert signal |
| tco_sci | input | 1 | SCI raised by the TCO logic |
| ac_wake | input | 1 | AC-link wake request |
| usb1_wake | input | 1 | USB controller 1 wake request |
| usb2_wake | input | 1 | USB controller 2 wake request |
| therm_trip | input | 1 | Thermal-trip event |
| pb_override | input | 1 | Power-button override event |
| wake_en | input | 16 | Per-flag wake enables, same bit positions as the status word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write-one-to-clear data |
| rd_data | output | 16 | Status word |
| wake_req | output | 1 | Combined wake request |

## Verification
Every flag is a single register that feeds `rd_data` directly, so a wrong flag value shows on the read port in the cycle after the faulty update. If the flag is enabled, `wake_req` shows the same error in that cycle. The stored SMBus cause is not visible at the ports. A wrong cause shows only when a thermal trip or button override arrives: bit 7 is then wrongly kept or wrongly cleared one cycle later. The bench therefore follows every SMBus set of each kind with both of these events. A missed ring-pin edge, or one detected twice, shows as bit 8 set or not set in the cycle after the pin moves.

// File: rtl/wake_status_reg.sv
module wake_status_reg #(
  parameter int DW     = 16,
  parameter int USB1_B = 3,
  parameter int USB2_B = 4,
  parameter int AC_B   = 5,
  parameter int TCO_B  = 6,
  parameter int SMB_B  = 7,
  parameter int RING_B = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_rst,
  input  logic          ring_n,
  input  logic          smb_msg,
  input  logic          smb_alert,
  input  logic          tco_sci,
  input  logic          ac_wake,
  input  logic          usb1_wake,
  input  logic          usb2_wake,
  input  logic          therm_trip,
  input  logic          pb_override,
  input  logic [DW-1:0] wake_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          wake_req
);
  localparam logic [DW-1:0] SMB_M = DW'(1) << SMB_B;

  logic [DW-1:0] st, set_v, clr_v, nxt;
  logic          ring_q, smb_by_alert;

  wire ring_fall = ring_q & ~ring_n;
  wire smb_set   = smb_msg | smb_alert;
  wire smb_auto  = (therm_trip | pb_override) & ~smb_by_alert & ~smb_set;

  always_comb begin
    set_v         = '0;
    set_v[USB1_B] = usb1_wake;
    set_v[USB2_B] = usb2_wake;
    set_v[AC_B]   = ac_wake;
    set_v[TCO_B]  = tco_sci;
    set_v[SMB_B]  = smb_set;
    set_v[RING_B] = ring_fall;
  end

  assign clr_v = wr_en ? wr_data : '0;

  always_comb begin
    nxt = set_v | (st & ~clr_v);
    if (smb_auto) nxt[SMB_B] = 1'b0;
    if (cfg_rst) begin
      nxt       = '0;
      nxt[AC_B] = set_v[AC_B] | (st[AC_B] & ~clr_v[AC_B]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= '0;
      ring_q       <= 1'b1;
      smb_by_alert <= 1'b0;
    end else begin
      st     <= nxt;
      ring_q <= ring_n;
      if (cfg_rst)      smb_by_alert <= 1'b0;
      else if (smb_set) smb_by_alert <= smb_alert;
    end
  end

  assign rd_data  = st;
  assign wake_req = |(st & (wake_en | SMB_M));

  // R2
  wr_zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[TCO_B] && st[TCO_B] && !cfg_rst) |=> rd_data[TCO_B]);

  // R5
  alert_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[SMB_B] && smb_by_alert && !(wr_en && wr_data[SMB_B]) && !cfg_rst) |=> rd_data[SMB_B]);

  // R6
  usb1_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (usb1_wake && !cfg_rst) |=> rd_data[USB1_B]);

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tco_sci && wr_en && wr_data[TCO_B] && !cfg_rst) |=> rd_data[TCO_B]);

  // R8
  cfg_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst |=> (rd_data[SMB_B] == 1'b0 && rd_data[RING_B] == 1'b0 && rd_data[USB1_B] == 1'b0));

  // R3
  ring_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ring_n) && !cfg_rst) |=> rd_data[RING_B]);
endmodule

// File: tb/sim_wake_status_reg.sv
`timescale 1ns/100ps
module sim_wake_status_reg;
  logic clk = 0, rst_n = 0, cfg_rst = 0, ring_n = 1;
  logic smb_msg = 0, smb_alert = 0, tco_sci = 0, ac_wake = 0, usb1_wake = 0, usb2_wake = 0;
  logic therm_trip = 0, pb_override = 0, wr_en = 0;
  logic [15:0] wake_en = '0, wr_data = '0, rd_data;
  logic wake_req;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [15:0] m_st = '0;
  bit m_alert = 0, m_ring_prev = 1;

  always #2.5 clk = ~clk;

  wake_status_reg u0 (.clk(clk), .rst_n(rst_n), .cfg_rst(cfg_rst), .ring_n(ring_n),
    .smb_msg(smb_msg), .smb_alert(smb_alert), .tco_sci(tco_sci), .ac_wake(ac_wake),
    .usb1_wake(usb1_wake), .usb2_wake(usb2_wake), .therm_trip(therm_trip),
    .pb_override(pb_override), .wake_en(wake_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wake_req(wake_req));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model();
    logic [15:0] s, c;
    bit ring_fall;
    if (!rst_n) begin
      m_st = '0; m_alert = 0; m_ring_prev = 1;
      return;
    end
    ring_fall = m_ring_prev && !ring_n;
    m_ring_prev = ring_n;
    c = wr_en ? wr_data : 16'h0;
    s = m_st & ~c;
    if (usb1_wake) s[3] = 1;
    if (usb2_wake) s[4] = 1;
    if (ac_wake)   s[5] = 1;
    if (tco_sci)   s[6] = 1;
    if (ring_fall) s[8] = 1;
    if (smb_msg || smb_alert) begin
      s[7] = 1;
      m_alert = smb_alert;
    end else if ((therm_trip || pb_override) && !m_alert) s[7] = 0;
    if (cfg_rst) begin
      s = s & 16'h0020;
      m_alert = 0;
    end
    m_st = s;
  endtask

  task automatic step();
    logic [15:0] en;
    @(posedge clk);
    #1;
    model();
    en = wake_en | 16'h0080;
    chk(cur_req, rd_data, m_st);
    chk({cur_req, " (R9 wake)"}, {15'd0, wake_req}, {15'd0, |(m_st & en & 16'h01F8)});
  endtask

  task automatic write(logic [15:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    step(); step();
    chk("R1", rd_data, 16'h0000);
    rst_n = 1;
    step();
    chk("R1", rd_data, 16'h0000);

    cur_req = "R6";
    usb1_wake = 1; step(); usb1_wake = 0;
    chk("R6", rd_data, 16'h0008);
    usb2_wake = 1; step(); usb2_wake = 0;
    ac_wake = 1; step(); ac_wake = 0;
    tco_sci = 1; step(); tco_sci = 0;
    chk("R6", rd_data, 16'h0078);

    cur_req = "R2";
    write(16'h0000);
    chk("R2", rd_data, 16'h0078);
    write(16'h0008);
    chk("R2", rd_data, 16'h0070);
    write(16'h0050);
    chk("R2", rd_data, 16'h0020);

    cur_req = "R10";
    write(16'hFFFF);
    chk("R10", rd_data, 16'h0000);

    cur_req = "R3";
    ring_n = 0; step();
    chk("R3", rd_data, 16'h0100);
    step(); write(16'h0100); step(); step();
    chk("R3", rd_data, 16'h0000);
    ring_n = 1; step(); ring_n = 0; step();
    chk("R3", rd_data, 16'h0100);
    ring_n = 1; write(16'h0100);

    cur_req = "R4";
    smb_msg = 1; step(); smb_msg = 0;
    chk("R4", rd_data, 16'h0080);
    cur_req = "R5";
    therm_trip = 1; step(); therm_trip = 0;
    chk("R5", rd_data, 16'h0000);
    smb_alert = 1; step(); smb_alert = 0;
    pb_override = 1; step(); pb_override = 0;
    therm_trip = 1; step(); therm_trip = 0;
    chk("R5", rd_data, 16'h0080);
    smb_msg = 1; step(); smb_msg = 0;
    pb_override = 1; step(); pb_override = 0;
    chk("R5", rd_data, 16'h0000);
    smb_msg = 1; smb_alert = 1; step(); smb_msg = 0; smb_alert = 0;
    therm_trip = 1; step(); therm_trip = 0;
    chk("R5", rd_data, 16'h0080);
    write(16'h0080);

    cur_req = "R7";
    tco_sci = 1; step(); tco_sci = 0;
    tco_sci = 1; write(16'h0040); tco_sci = 0;
    chk("R7", rd_data, 16'h0040);
    write(16'h0040);

    cur_req = "R9";
    wake_en = 16'h0000;
    usb1_wake = 1; step(); usb1_wake = 0;
    chk("R9", {15'd0, wake_req}, 16'h0000);
    wake_en = 16'h0008; step();
    chk("R9", {15'd0, wake_req}, 16'h0001);
    wake_en = 16'h0000; write(16'h0008);
    smb_msg = 1; step(); smb_msg = 0;
    chk("R9", {15'd0, wake_req}, 16'h0001);
    write(16'h0080);
    wake_en = 16'hFFFF; step();
    chk("R9", {15'd0, wake_req}, 16'h0000);

    cur_req = "R8";
    usb2_wake = 1; ac_wake = 1; tco_sci = 1; step();
    usb2_wake = 0; ac_wake = 0; tco_sci = 0;
    smb_msg = 1; ring_n = 0; step(); smb_msg = 0;
    chk("R8", rd_data, 16'h01F0);
    cfg_rst = 1; usb1_wake = 1; step(); cfg_rst = 0; usb1_wake = 0;
    chk("R8", rd_data, 16'h0020);
    smb_msg = 1; step(); smb_msg = 0;
    therm_trip = 1; step(); therm_trip = 0;
    chk("R8", rd_data, 16'h0020);
    cfg_rst = 1; write(16'h0020); cfg_rst = 0;
    chk("R8", rd_data, 16'h0000);
    ring_n = 1; step(); step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule